// File: doc/BRIEF.md
# Four-Lane Receive Deskew Aligner

This block lines up four parallel receive lanes of a XAUI-style link that share one clock. Each lane hands over one decoded byte per cycle, together with a control flag and a synchronization status from its word aligner. The lanes may arrive skewed against each other by several cycles. The transmitter places an alignment character on all four lanes in the same column during the inter-packet gap. The block finds that character on each lane and buffers every lane from that point on. It then releases all four lanes together, so the alignment characters and everything after them come out as one column.

Each lane owns a small circular buffer. A lane starts storing on its own first alignment character. Reading is held on every lane until all four have seen the character within a bounded window. All four lanes then start reading in the same cycle. If the window runs out, the search is abandoned with a one-cycle fail pulse and starts again. If a lane loses synchronization, the block flushes all buffers and waits. Once aligned, a later alignment column that is split across lanes twice in a row means the alignment has slipped, and the search starts again.

Top module: `lane_deskew4`

## Requirements
- R1: While any lane's sync input is low, the aligned flag stays low and no output is valid. A drop of sync on any lane clears the aligned flag, the buffers are flushed, and the search resumes once all four lanes are synchronized again.
- R2: The alignment character is a byte with the control flag at 1 and value 0x7C. A byte 0x7C with the control flag at 0 is ordinary data and never starts or completes an alignment.
- R3: A lane stores nothing before its first alignment character. After a release, the first valid output column holds the alignment character (control 1, 0x7C) on all four lanes.
- R4: From its first alignment character on, a lane stores every received word while its reads stay held. After the release, each lane's output reproduces its input stream in order, starting at that character.
- R5: When the last lane's alignment character arrives no more than 10 cycles after the first lane's, the aligned flag rises and all four lanes begin reading in the same cycle. Columns leave the block as they were sent.
- R6: When 10 cycles have passed since the first alignment character and some lane still has not seen one, fail pulses high for exactly one cycle. The aligned flag stays low, and the search restarts with empty buffers.
- R7: The output valid flag is low whenever the aligned flag is low.
- R8: While aligned, an output column that has the alignment character on some lanes but not all is a split column. Two split columns in a row among the columns carrying that character drop the aligned flag and restart the search. A full alignment column between them cancels the first split column.
- R9: After reset, the aligned flag, the output valid flag and the fail flag are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared lane clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lane_data_i | input | 32 | Received bytes, lane k in bits 8k+7..8k |
| lane_ctrl_i | input | 4 | Control flag per lane, bit k for lane k |
| lane_sync_i | input | 4 | Word-aligner synchronized status per lane |
| out_data_o | output | 32 | Aligned bytes, same lane packing as the input |
| out_ctrl_o | output | 4 | Aligned control flags |
| out_valid_o | output | 1 | The output column is valid |
| aligned_o | output | 1 | The lanes are deskewed and reading |
| fail_o | output | 1 | One-cycle pulse when the window runs out |

## Verification
The hardest state to reach from the ports is the slip detector after alignment. It needs a link that is already aligned, followed by a split alignment column, then a full one, then two more split columns. Only the last pair may drop the flag. The stimulus builds the lanes from a single column script that is delayed by a different amount per lane, so split and full columns reach the output exactly where the script places them. The bench samples the aligned flag between the tolerated split column and the fatal pair. Window edge cases use skew sets spread by exactly 10 and by 11 cycles.

// File: rtl/deskew_pkg.sv
package deskew_pkg;
  typedef enum logic [1:0] {
    ST_WAIT    = 2'd0,
    ST_SEARCH  = 2'd1,
    ST_FILL    = 2'd2,
    ST_ALIGNED = 2'd3
  } dsk_state_e;

  typedef struct packed {
    logic       ctrl;
    logic [7:0] data;
  } lane_word_t;
endpackage

// File: rtl/lane_fifo.sv
module lane_fifo
  import deskew_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       flush_i,
  input  logic       wr_en_i,
  input  logic       rd_en_i,
  input  lane_word_t wr_word_i,
  output lane_word_t rd_word_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  lane_word_t    mem [DEPTH];
  logic [AW-1:0] wr_ptr, wr_ptr_n;
  logic [AW-1:0] rd_ptr, rd_ptr_n;

  // pointer next-state
  always_comb begin
    wr_ptr_n = wr_ptr;
    rd_ptr_n = rd_ptr;
    if (flush_i) begin
      wr_ptr_n = '0;
      rd_ptr_n = '0;
    end else begin
      if (wr_en_i) wr_ptr_n = (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (rd_en_i) rd_ptr_n = (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      wr_ptr <= wr_ptr_n;
      rd_ptr <= rd_ptr_n;
    end
  end

  // storage: no reset, only written entries are ever read
  always_ff @(posedge clk) begin
    if (wr_en_i && !flush_i) mem[wr_ptr] <= wr_word_i;
  end

  assign rd_word_o = mem[rd_ptr];
endmodule

// File: rtl/align_column.sv
module align_column
  import deskew_pkg::*;
#(
  parameter int         LANES      = 4,
  parameter logic [7:0] ALIGN_CHAR = 8'h7C
) (
  input  lane_word_t [LANES-1:0] words_i,
  output logic       [LANES-1:0] hit_o
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign hit_o[k] = words_i[k].ctrl && (words_i[k].data == ALIGN_CHAR);
  end
endmodule

// File: rtl/deskew_ctrl.sv
module deskew_ctrl
  import deskew_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int WINDOW = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             all_sync_i,
  input  logic [LANES-1:0] in_hit_i,
  input  logic [LANES-1:0] col_hit_i,
  output dsk_state_e       state_o,
  output logic [LANES-1:0] seen_o,
  output logic             flush_o,
  output logic             fail_o
);
  localparam int CW = $clog2(WINDOW + 1);
  localparam logic [CW-1:0] CNT_LIMIT = CW'(WINDOW);

  dsk_state_e       state, state_n;
  logic [LANES-1:0] seen, seen_n;
  logic [CW-1:0]    cnt, cnt_n;
  logic             miss, miss_n;
  logic             fail_n;
  logic             in_any, in_all, col_any, col_all;

  assign in_any  = |in_hit_i;
  assign in_all  = &in_hit_i;
  assign col_any = |col_hit_i;
  assign col_all = &col_hit_i;

  always_comb begin
    state_n = state;
    seen_n  = seen;
    cnt_n   = cnt;
    miss_n  = miss;
    flush_o = 1'b0;
    fail_n  = 1'b0;
    if (!all_sync_i) begin
      state_n = ST_WAIT;
      seen_n  = '0;
      cnt_n   = '0;
      miss_n  = 1'b0;
      flush_o = 1'b1;
    end else begin
      unique case (state)
        ST_WAIT: begin
          state_n = ST_SEARCH;
          flush_o = 1'b1;
        end
        ST_SEARCH: begin
          if (in_any) begin
            seen_n  = in_hit_i;
            cnt_n   = in_all ? '0 : CW'(1);
            state_n = in_all ? ST_ALIGNED : ST_FILL;
          end
        end
        ST_FILL: begin
          seen_n = seen | in_hit_i;
          if (&seen_n) begin
            state_n = ST_ALIGNED;
            cnt_n   = '0;
          end else if (cnt >= CNT_LIMIT) begin
            fail_n  = 1'b1;
            flush_o = 1'b1;
            state_n = ST_SEARCH;
            seen_n  = '0;
            cnt_n   = '0;
          end else begin
            cnt_n = cnt + 1'b1;
          end
        end
        ST_ALIGNED: begin
          if (col_any && !col_all) begin
            if (miss) begin
              flush_o = 1'b1;
              state_n = ST_SEARCH;
              seen_n  = '0;
              miss_n  = 1'b0;
            end else begin
              miss_n = 1'b1;
            end
          end else if (col_all) begin
            miss_n = 1'b0;
          end
        end
        default: state_n = ST_WAIT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_WAIT;
      seen   <= '0;
      cnt    <= '0;
      miss   <= 1'b0;
      fail_o <= 1'b0;
    end else begin
      state  <= state_n;
      seen   <= seen_n;
      cnt    <= cnt_n;
      miss   <= miss_n;
      fail_o <= fail_n;
    end
  end

  assign state_o = state;
  assign seen_o  = seen;
endmodule

// File: rtl/lane_deskew4.sv
module lane_deskew4
  import deskew_pkg::*;
#(
  parameter int         LANES      = 4,
  parameter int         DEPTH      = 16,
  parameter int         WINDOW     = 10,
  parameter logic [7:0] ALIGN_CHAR = 8'h7C
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LANES*8-1:0] lane_data_i,
  input  logic [LANES-1:0]   lane_ctrl_i,
  input  logic [LANES-1:0]   lane_sync_i,
  output logic [LANES*8-1:0] out_data_o,
  output logic [LANES-1:0]   out_ctrl_o,
  output logic               out_valid_o,
  output logic               aligned_o,
  output logic               fail_o
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_int = rst_sync[1];

  lane_word_t [LANES-1:0] in_words, rd_words, out_q;
  logic       [LANES-1:0] in_hit, col_hit, seen, wr_en;
  dsk_state_e             state;
  logic                   flush, rd_en, collecting;

  for (genvar k = 0; k < LANES; k++) begin : g_in
    assign in_words[k].ctrl = lane_ctrl_i[k];
    assign in_words[k].data = lane_data_i[k*8 +: 8];
  end

  align_column #(.LANES(LANES), .ALIGN_CHAR(ALIGN_CHAR)) u_in_match (
    .words_i (in_words),
    .hit_o   (in_hit)
  );

  align_column #(.LANES(LANES), .ALIGN_CHAR(ALIGN_CHAR)) u_out_match (
    .words_i (rd_words),
    .hit_o   (col_hit)
  );

  deskew_ctrl #(.LANES(LANES), .WINDOW(WINDOW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .all_sync_i (&lane_sync_i),
    .in_hit_i   (in_hit),
    .col_hit_i  (col_hit),
    .state_o    (state),
    .seen_o     (seen),
    .flush_o    (flush),
    .fail_o     (fail_o)
  );

  assign collecting = (state == ST_SEARCH) || (state == ST_FILL);
  assign rd_en      = (state == ST_ALIGNED) && !flush;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign wr_en[k] = !flush &&
                      ((collecting && (seen[k] || in_hit[k])) || (state == ST_ALIGNED));

    lane_fifo #(.DEPTH(DEPTH)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n_int),
      .flush_i   (flush),
      .wr_en_i   (wr_en[k]),
      .rd_en_i   (rd_en),
      .wr_word_i (in_words[k]),
      .rd_word_o (rd_words[k])
    );

    assign out_data_o[k*8 +: 8] = out_q[k].data;
    assign out_ctrl_o[k]        = out_q[k].ctrl;
  end

  // output column register with explicit enable
  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      out_q       <= '0;
      out_valid_o <= 1'b0;
    end else begin
      out_valid_o <= rd_en;
      if (rd_en) out_q <= rd_words;
    end
  end

  assign aligned_o = (state == ST_ALIGNED);
endmodule

// File: rtl/lane_deskew4_chk.sv
module lane_deskew4_chk #(
  parameter int         LANES      = 4,
  parameter logic [7:0] ALIGN_CHAR = 8'h7C
) (
  input logic               clk,
  input logic               rst_n,
  input logic [LANES-1:0]   lane_sync_i,
  input logic [LANES*8-1:0] out_data_o,
  input logic [LANES-1:0]   out_ctrl_o,
  input logic               out_valid_o,
  input logic               aligned_o,
  input logic               fail_o
);
  logic out_all_align;

  always_comb begin
    out_all_align = 1'b1;
    for (int k = 0; k < LANES; k++) begin
      if (!out_ctrl_o[k] || (out_data_o[k*8 +: 8] != ALIGN_CHAR)) out_all_align = 1'b0;
    end
  end

  p_sync_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(&lane_sync_i) |=> !aligned_o);

  p_first_column_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid_o) |-> out_all_align);

  p_valid_needs_aligned_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |-> aligned_o);

  p_fail_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fail_o |=> !fail_o);

  p_fail_unaligned_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fail_o |-> !aligned_o);
endmodule

bind lane_deskew4 lane_deskew4_chk #(.LANES(LANES), .ALIGN_CHAR(ALIGN_CHAR)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .lane_sync_i (lane_sync_i),
  .out_data_o  (out_data_o),
  .out_ctrl_o  (out_ctrl_o),
  .out_valid_o (out_valid_o),
  .aligned_o   (aligned_o),
  .fail_o      (fail_o)
);

// File: tb/lane_deskew4_test.sv
module lane_deskew4_test;
  localparam int LANES = 4;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [LANES*8-1:0] lane_data_i;
  logic [LANES-1:0]  lane_ctrl_i, lane_sync_i;
  logic [LANES*8-1:0] out_data_o;
  logic [LANES-1:0]  out_ctrl_o;
  logic              out_valid_o, aligned_o, fail_o;

  always #10 clk = ~clk;

  lane_deskew4 uut (
    .clk(clk), .rst_n(rst_n),
    .lane_data_i(lane_data_i), .lane_ctrl_i(lane_ctrl_i), .lane_sync_i(lane_sync_i),
    .out_data_o(out_data_o), .out_ctrl_o(out_ctrl_o),
    .out_valid_o(out_valid_o), .aligned_o(aligned_o), .fail_o(fail_o)
  );

  int errors = 0;
  int checks = 0;

  // column script: 0 idle, 1 full align, 2 data, 3 split align (lanes 0,1), 4 data 0x7C
  int kind [256];
  int skew [LANES];
  int sync_off_lane, sync_off_from, sync_off_to;
  int probe_t;
  logic probe_aligned, probe_valid;

  logic [31:0] exp_d [$];
  logic [3:0]  exp_c [$];
  bit          exp_a [$];

  int valid_cnt, fail_cnt, fail_double, cmp_cnt;
  bit aligned_seen, prev_valid, prev_fail;

  task automatic check(bit ok, string req, string what, longint act, longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic logic [8:0] src_word(int j, int k);
    logic [7:0] d;
    d = 8'((j * 7 + k * 29 + 3) % 256);
    if (d == 8'h7C) d = 8'h7D;
    case (kind[j])
      1:       return {1'b1, 8'h7C};
      2:       return {1'b0, d};
      3:       return (k < 2) ? {1'b1, 8'h7C} : {1'b0, d};
      4:       return {1'b0, 8'h7C};
      default: return {1'b1, 8'h07};
    endcase
  endfunction

  task automatic clear_script();
    for (int j = 0; j < 256; j++) kind[j] = 0;
    sync_off_lane = -1; sync_off_from = 0; sync_off_to = 0;
    probe_t = -1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    lane_data_i = {LANES{8'h07}};
    lane_ctrl_i = '1;
    lane_sync_i = '1;
    exp_d.delete(); exp_c.delete(); exp_a.delete();
    valid_cnt = 0; fail_cnt = 0; fail_double = 0; cmp_cnt = 0;
    aligned_seen = 0; prev_valid = 0; prev_fail = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (4) @(posedge clk);
  endtask

  // driver: lanes take the script delayed by their skew; expected columns queued
  task automatic run(int len, int first_a);
    for (int t = 0; t < len; t++) begin
      @(posedge clk);
      #2;
      for (int k = 0; k < LANES; k++) begin
        logic [8:0] w;
        int j;
        j = t - skew[k];
        w = (j >= 0) ? src_word(j, k) : {1'b1, 8'h07};
        lane_ctrl_i[k] = w[8];
        lane_data_i[k*8 +: 8] = w[7:0];
        lane_sync_i[k] = !(k == sync_off_lane && t >= sync_off_from && t < sync_off_to);
      end
      if (t >= first_a) begin
        logic [31:0] d;
        logic [3:0]  c;
        for (int k = 0; k < LANES; k++) begin
          logic [8:0] w;
          w = src_word(t, k);
          c[k] = w[8];
          d[k*8 +: 8] = w[7:0];
        end
        exp_d.push_back(d); exp_c.push_back(c); exp_a.push_back(kind[t] == 1);
      end
      if (t == probe_t) begin
        probe_aligned = aligned_o;
        probe_valid   = out_valid_o;
      end
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (aligned_o) aligned_seen = 1;
      if (fail_o) begin
        fail_cnt++;
        if (prev_fail) fail_double++;
      end
      if (out_valid_o) begin
        valid_cnt++;
        if (!prev_valid) begin
          while (exp_a.size() > 0 && !exp_a[0]) begin
            void'(exp_d.pop_front()); void'(exp_c.pop_front()); void'(exp_a.pop_front());
          end
          check(out_ctrl_o == 4'hF && out_data_o == {LANES{8'h7C}}, "R3",
                "first column after release", {out_ctrl_o, out_data_o}, {4'hF, {LANES{8'h7C}}});
        end
        if (exp_d.size() == 0) begin
          check(0, "R4", "output with empty scoreboard", {out_ctrl_o, out_data_o}, 0);
        end else begin
          logic [31:0] ed;
          logic [3:0]  ec;
          ed = exp_d.pop_front(); ec = exp_c.pop_front(); void'(exp_a.pop_front());
          cmp_cnt++;
          check(out_data_o == ed && out_ctrl_o == ec, "R4 R5", "aligned column",
                {out_ctrl_o, out_data_o}, {ec, ed});
        end
      end
      prev_valid = out_valid_o;
      prev_fail  = fail_o;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R9: reset state
    clear_script();
    do_reset();
    @(negedge clk);
    check(aligned_o == 0, "R9", "aligned after reset", aligned_o, 0);
    check(out_valid_o == 0, "R9", "valid after reset", out_valid_o, 0);
    check(fail_o == 0, "R9", "fail after reset", fail_o, 0);

    // R1: one lane never synchronized
    clear_script();
    for (int j = 5; j < 60; j++) kind[j] = 2;
    kind[4] = 1; kind[30] = 1;
    skew = '{0, 0, 0, 0};
    sync_off_lane = 1; sync_off_from = 0; sync_off_to = 1000;
    do_reset();
    run(50, 1000);
    @(negedge clk);
    check(aligned_seen == 0, "R1", "aligned without sync", aligned_seen, 0);
    check(valid_cnt == 0, "R1", "valid cycles without sync", valid_cnt, 0);

    // R2: control-0 0x7C bytes never align
    clear_script();
    for (int j = 2; j < 40; j++) kind[j] = (j % 3 == 0) ? 4 : 2;
    skew = '{0, 1, 2, 3};
    do_reset();
    run(40, 1000);
    @(negedge clk);
    check(aligned_seen == 0, "R2", "aligned on data 0x7C", aligned_seen, 0);

    // R4 R5: spread of exactly 10 cycles
    clear_script();
    for (int j = 6; j < 100; j++) kind[j] = 2;
    kind[5] = 1; kind[12] = 4; kind[50] = 1;
    skew = '{0, 3, 7, 10};
    do_reset();
    run(90, 5);
    @(negedge clk);
    check(aligned_o == 1, "R5", "aligned after spread 10", aligned_o, 1);
    check(cmp_cnt >= 60, "R5", "compared columns", cmp_cnt, 60);
    check(fail_cnt == 0, "R5", "fail pulses at spread 10", fail_cnt, 0);

    // R6: spread of 11 cycles
    clear_script();
    for (int j = 5; j < 80; j++) kind[j] = 2;
    kind[4] = 1;
    skew = '{0, 11, 2, 5};
    do_reset();
    run(60, 1000);
    @(negedge clk);
    check(fail_cnt >= 1, "R6", "fail pulses at spread 11", fail_cnt, 1);
    check(fail_double == 0, "R6", "fail high two cycles", fail_double, 0);
    check(aligned_seen == 0, "R6", "aligned at spread 11", aligned_seen, 0);
    check(valid_cnt == 0, "R7", "valid while never aligned", valid_cnt, 0);

    // R8: split align columns
    clear_script();
    for (int j = 5; j < 80; j++) kind[j] = 2;
    kind[4] = 1; kind[21] = 3; kind[26] = 1; kind[31] = 3; kind[36] = 3;
    skew = '{2, 0, 1, 3};
    probe_t = 37;
    do_reset();
    run(60, 4);
    @(negedge clk);
    check(probe_aligned == 1, "R8", "aligned after single split column", probe_aligned, 1);
    check(aligned_o == 0, "R8", "aligned after two split columns", aligned_o, 0);
    check(valid_cnt >= 25, "R8", "valid columns before slip", valid_cnt, 25);

    // R1 R7: sync loss while aligned, then reacquire
    clear_script();
    for (int j = 5; j < 90; j++) kind[j] = 2;
    kind[4] = 1; kind[40] = 1;
    skew = '{1, 1, 1, 1};
    sync_off_lane = 2; sync_off_from = 30; sync_off_to = 33;
    probe_t = 32;
    do_reset();
    run(70, 4);
    @(negedge clk);
    check(probe_aligned == 0, "R1", "aligned after sync loss", probe_aligned, 0);
    check(probe_valid == 0, "R7", "valid after sync loss", probe_valid, 0);
    check(aligned_o == 1, "R1", "aligned after sync returns", aligned_o, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule